// File: doc/BRIEF.md
# Universal Shift Register with Shared I/O

An eight-bit register, clocked on the rising edge, that can keep its contents, shift one place toward the higher bit positions, shift one place toward the lower bit positions, or take a whole word in parallel. The same eight pins carry the parallel input word and the register's output. In the block these pins appear as an input bus, an output bus and a single bus-enable. A tri-state pad or wrapper combines them into the physical pins.

A two-bit mode select picks the operation. An active-low synchronous reset overrides the mode and clears the word. Two active-low enables control whether the register value drives the shared pins. The drive is also dropped whenever parallel load is selected, so that outside logic can put the new word on the pins. Two dedicated outputs always show the lowest and the highest bit, and two serial inputs feed the end bits during shifts. Several registers can therefore be chained into a longer word, with each tap output wired to the neighbour's serial input.

The operation is decoded into a named operation state: OP_CLEAR, OP_HOLD, OP_UP, OP_DOWN or OP_LOAD. It is chosen fresh each cycle and has no transition history. An active reset moves the decoder to OP_CLEAR. Otherwise mode 00 selects OP_HOLD, 01 selects OP_UP, 10 selects OP_DOWN and 11 selects OP_LOAD. Every rising edge applies the selected operation to the register.

Top module: `universal_shift_reg`

## Requirements
- R1: When rst_n is 0 at a rising clock edge, all bits become 0, whatever the value of mode_sel.
- R2: With rst_n at 1 and mode_sel = 2'b11, each bit n takes pbus_in[n] at the rising edge.
- R3: With rst_n at 1 and mode_sel = 2'b01, bit 0 takes ser_in_lo and each bit n takes the previous bit n-1 (shift toward higher positions).
- R4: With rst_n at 1 and mode_sel = 2'b10, bit 7 takes ser_in_hi and each bit n takes the previous bit n+1 (shift toward lower positions).
- R5: With rst_n at 1 and mode_sel = 2'b00, the register keeps its value.
- R6: pbus_oe is 1 only when out_en_a_n and out_en_b_n are both 0 and mode_sel is not 2'b11. pbus_out always carries the register value, so in load mode outside data can drive the pins without a conflict.
- R7: Clear, shift, load and hold work the same way while pbus_oe is 0.
- R8: tap_lo always equals bit 0 and tap_hi always equals bit 7, whatever the state of the enables.
- R9: The register changes only at a rising clock edge. Input changes between edges leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous clear, active low |
| mode_sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 on shift up |
| ser_in_hi | input | 1 | Serial bit entering bit 7 on shift down |
| out_en_a_n | input | 1 | Bus enable A, active low |
| out_en_b_n | input | 1 | Bus enable B, active low |
| pbus_in | input | 8 | Value seen on the shared pins |
| pbus_out | output | 8 | Register value for the shared pins |
| pbus_oe | output | 1 | Drive enable for the shared pins |
| tap_lo | output | 1 | Bit 0, always driven |
| tap_hi | output | 1 | Bit 7, always driven |

## Verification
The bench attaches the shared pins through a resolved wire with two conditional drivers. It loads words while it drives that wire itself. A design that kept driving in load mode would corrupt the loaded value or show a drive conflict on the pins.

Shifts run in both directions with both serial input values, including a walking one that crosses the end bit. A swapped neighbour or a wrong end input would show up in pbus_out or in the taps. Reset is applied while a shift is selected, and a design that let the mode win over reset would keep stale bits. Operations also run with the bus disabled, and mode inputs change between edges. A design that gated the register with the enables, or that was not edge-bound, would then differ from the model.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR = 3'd0,
        OP_HOLD  = 3'd1,
        OP_UP    = 3'd2,
        OP_DOWN  = 3'd3,
        OP_LOAD  = 3'd4
    } usr_op_e;

    localparam logic [1:0] MODE_HOLD = 2'b00;
    localparam logic [1:0] MODE_UP   = 2'b01;
    localparam logic [1:0] MODE_DOWN = 2'b10;
    localparam logic [1:0] MODE_LOAD = 2'b11;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output usr_op_e    op
);

    always_comb begin
        op = OP_HOLD;
        if (!rst_n) begin
            op = OP_CLEAR;
        end else begin
            unique case (mode_sel)
                MODE_HOLD: op = OP_HOLD;
                MODE_UP:   op = OP_UP;
                MODE_DOWN: op = OP_DOWN;
                MODE_LOAD: op = OP_LOAD;
                default:   op = OP_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  usr_op_e          op,
    input  logic             ser_lo,
    input  logic             ser_hi,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] from_below;
    logic [WIDTH-1:0] from_above;
    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == 0) begin : g_low_end
            assign from_below[i] = ser_lo;
        end else begin : g_low_mid
            assign from_below[i] = q[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign from_above[i] = ser_hi;
        end else begin : g_high_mid
            assign from_above[i] = q[i+1];
        end

        always_comb begin
            nxt[i] = q[i];
            unique case (op)
                OP_CLEAR: nxt[i] = 1'b0;
                OP_HOLD:  nxt[i] = q[i];
                OP_UP:    nxt[i] = from_below[i];
                OP_DOWN:  nxt[i] = from_above[i];
                OP_LOAD:  nxt[i] = par_in[i];
                default:  nxt[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (q == $past(par_in))); // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UP) |=> (q == {$past(q[TOP-1:0]), $past(ser_lo)})); // R3

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN) |=> (q == {$past(ser_hi), $past(q[TOP:1])})); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(q)); // R5

endmodule

// File: rtl/usr_bus_gate.sv
module usr_bus_gate
    import usr_pkg::*;
(
    input  logic       en_a_n,
    input  logic       en_b_n,
    input  logic [1:0] mode_sel,
    output logic       oe
);

    logic load_sel;

    always_comb begin
        load_sel = (mode_sel == MODE_LOAD);
        oe       = !(en_a_n || en_b_n || load_sel);
    end

endmodule

// File: rtl/universal_shift_reg.sv
module universal_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_in_lo,
    input  logic             ser_in_hi,
    input  logic             out_en_a_n,
    input  logic             out_en_b_n,
    input  logic [WIDTH-1:0] pbus_in,
    output logic [WIDTH-1:0] pbus_out,
    output logic             pbus_oe,
    output logic             tap_lo,
    output logic             tap_hi
);

    localparam int TOP = WIDTH - 1;

    usr_op_e          op;
    logic [WIDTH-1:0] word;

    usr_mode_decode u_decode (
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .op       (op)
    );

    usr_stage_array #(.WIDTH(WIDTH)) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_lo (ser_in_lo),
        .ser_hi (ser_in_hi),
        .par_in (pbus_in),
        .q      (word)
    );

    usr_bus_gate u_gate (
        .en_a_n   (out_en_a_n),
        .en_b_n   (out_en_b_n),
        .mode_sel (mode_sel),
        .oe       (pbus_oe)
    );

    always_comb begin
        pbus_out = word;
        tap_lo   = word[0];
        tap_hi   = word[TOP];
    end

    AST_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_a_n || out_en_b_n || (mode_sel == 2'b11)) |-> !pbus_oe); // R6

    AST_BUS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en_a_n && !out_en_b_n && (mode_sel != 2'b11)) |-> pbus_oe); // R6

endmodule

// File: tb/universal_shift_reg_test.sv
`timescale 1ns/1ps
module universal_shift_reg_test;

    typedef struct {
        logic [7:0] q;
        logic       oe;
        logic       drive;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       ser_in_lo = 1'b0;
    logic       ser_in_hi = 1'b0;
    logic       out_en_a_n = 1'b1;
    logic       out_en_b_n = 1'b1;
    logic       drv_en = 1'b0;
    logic [7:0] drv_val = 8'h00;
    logic [7:0] pbus_out;
    logic       pbus_oe;
    logic       tap_lo;
    logic       tap_hi;
    wire  [7:0] pins;

    assign pins = pbus_oe ? pbus_out : 8'bz;
    assign pins = drv_en ? drv_val : 8'bz;

    universal_shift_reg uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .ser_in_lo  (ser_in_lo),
        .ser_in_hi  (ser_in_hi),
        .out_en_a_n (out_en_a_n),
        .out_en_b_n (out_en_b_n),
        .pbus_in    (pins),
        .pbus_out   (pbus_out),
        .pbus_oe    (pbus_oe),
        .tap_lo     (tap_lo),
        .tap_hi     (tap_hi)
    );

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    exp_t sb[$];
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic rst, input logic [1:0] mode, input logic lo, input logic hi,
                        input logic ea, input logic eb, input logic drive, input logic [7:0] data,
                        input string tag, input bit mid);
        exp_t it;
        @(negedge clk);
        rst_n = rst; mode_sel = mode; ser_in_lo = lo; ser_in_hi = hi;
        out_en_a_n = ea; out_en_b_n = eb; drv_en = drive; drv_val = data;
        #1;
        if (mid) chk(pbus_out === model, "R9 between edges", {24'd0, pbus_out}, {24'd0, model});
        if (!rst) model = 8'h00;
        else begin
            case (mode)
                2'b00: model = model;
                2'b01: model = {model[6:0], lo};
                2'b10: model = {hi, model[7:1]};
                default: model = data;
            endcase
        end
        it.q = model;
        it.oe = !(ea || eb || (mode == 2'b11));
        it.drive = drive;
        it.data = data;
        it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk(pbus_out === it.q, it.tag, {24'd0, pbus_out}, {24'd0, it.q});
                chk(tap_lo === it.q[0], "R8 tap_lo", {31'd0, tap_lo}, {31'd0, it.q[0]});
                chk(tap_hi === it.q[7], "R8 tap_hi", {31'd0, tap_hi}, {31'd0, it.q[7]});
                chk(pbus_oe === it.oe, "R6 bus enable", {31'd0, pbus_oe}, {31'd0, it.oe});
                if (it.oe) chk(pins === it.q, "R6 pins driven", {24'd0, pins}, {24'd0, it.q});
                if (it.drive && !it.oe) chk(pins === it.data, "R6 no conflict", {24'd0, pins}, {24'd0, it.data});
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset overrides a load request
        step(0, 2'b11, 0, 0, 1, 1, 1, 8'h5A, "R1 reset over load", 0);
        step(0, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R1 reset idle", 0);
        // R2: load while the bench drives the pins
        step(1, 2'b11, 0, 0, 0, 0, 1, 8'hA5, "R2 load A5", 1);
        step(1, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R5 hold A5", 1);
        // R3: shift toward higher bits
        step(1, 2'b01, 1, 0, 0, 0, 0, 8'h00, "R3 up in1", 1);
        step(1, 2'b01, 0, 1, 0, 0, 0, 8'h00, "R3 up in0", 1);
        step(1, 2'b01, 1, 0, 0, 1, 0, 8'h00, "R3 up in1 bus off", 1);
        // R4: shift toward lower bits
        step(1, 2'b10, 1, 0, 0, 0, 0, 8'h00, "R4 down in0", 1);
        step(1, 2'b10, 0, 1, 0, 0, 0, 8'h00, "R4 down in1", 1);
        // R5/R6: hold under each enable combination
        step(1, 2'b00, 1, 1, 1, 0, 0, 8'h00, "R5 hold ena_a off", 1);
        step(1, 2'b00, 0, 0, 0, 1, 0, 8'h00, "R5 hold ena_b off", 1);
        step(1, 2'b00, 1, 1, 1, 1, 0, 8'h00, "R5 hold both off", 1);
        // R7: operations while the bus is disabled
        step(1, 2'b11, 0, 0, 1, 1, 1, 8'h3C, "R7 load bus off", 1);
        step(1, 2'b10, 0, 1, 1, 0, 0, 8'h00, "R7 down bus off", 1);
        step(1, 2'b01, 1, 0, 0, 1, 0, 8'h00, "R7 up bus off", 1);
        step(0, 2'b01, 1, 1, 1, 1, 0, 8'h00, "R7 reset bus off", 1);
        // walking one up across the top bit
        step(1, 2'b01, 1, 0, 0, 0, 0, 8'h00, "R3 walk start", 1);
        for (int k = 0; k < 8; k++)
            step(1, 2'b01, 0, 0, 0, 0, 0, 8'h00, "R3 walk", 1);
        // full load then drain down with 0
        step(1, 2'b11, 0, 0, 0, 0, 1, 8'hFF, "R2 load FF", 1);
        for (int k = 0; k < 8; k++)
            step(1, 2'b10, 0, 0, 0, 0, 0, 8'h00, "R4 drain", 1);
        // R1: reset while a shift is selected
        step(1, 2'b11, 0, 0, 0, 0, 1, 8'h81, "R2 load 81", 1);
        step(0, 2'b10, 0, 1, 0, 0, 0, 8'h00, "R1 reset over shift", 1);
        step(1, 2'b10, 0, 1, 0, 0, 0, 8'h00, "R4 after reset", 1);
        step(1, 2'b00, 0, 0, 0, 0, 0, 8'h00, "R5 final hold", 1);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule